// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block translates virtual page numbers into physical addresses for both instruction and data accesses. It is fully associative: every lookup compares the virtual address against all entries at the same time. Each entry covers an even/odd pair of adjacent virtual pages. Each entry also carries its own page size, anywhere from 4 KiB to 16 MiB, its own address space identifier, a global flag, and a physical frame number and valid bit for each half of the pair.

Software fills entries through a write port. The port either names the target entry directly or asks for a random victim. A register holding a locked count keeps the lowest entries out of random replacement, so mappings that must stay resident are never evicted. A lookup returns hit, miss and the physical address one clock after it is presented. Raising exceptions on a miss and refilling the buffer are the job of the surrounding logic.

Top module: `ptlb_top`

## Requirements
- R1: After reset every entry is invalid and `res_valid`, `res_hit`, `res_miss` and `res_pa` are 0; any lookup then reports a miss.
- R2: A lookup presented with `lk_valid` high is answered on the next cycle with `res_valid` high and exactly one of `res_hit`/`res_miss` high. Without `lk_valid`, all three stay low on the next cycle.
- R3: An entry's tag matches when `lk_va[VA_W-1:13]` equals the stored pair number in every bit not ignored by its size, and either the entry is global or its identifier equals `lk_asid`.
- R4: Size code k (0..6) gives a page of 4 KiB·4^k; code 7 behaves as code 6. The low 2k bits of the pair number are ignored. `lk_va[12+2k]` picks the odd (1) or even (0) half. `res_pa` is the chosen frame number shifted left by 12, with its low 12+2k bits replaced by `lk_va`.
- R5: A tag match whose selected half has its valid bit clear reports a miss, with `res_pa` 0.
- R6: An indexed write (`wr_en`, `wr_rand` low) replaces entry `wr_idx`. A lookup in the same cycle as a write still sees the old contents; the lookup in the following cycle sees the new ones.
- R7: The random victim index counts down by one each cycle. After the locked count it wraps to the top entry (NUM_ENTRIES-1). It returns to the top entry on reset and in the cycle after a write to the locked count. A random write (`wr_en`, `wr_rand` high) therefore never changes an entry below the locked count.
- R8: When more than one entry matches the tag, the lowest-numbered matching entry alone decides hit, miss and address, including when its selected half is invalid.
- R9: An indexed write whose `wr_idx` is NUM_ENTRIES or more changes no entry.
- R10: A non-global entry does not match when `lk_asid` differs from its identifier; a global entry matches for any `lk_asid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address space identifier |
| wr_en | input | 1 | Write an entry this cycle |
| wr_rand | input | 1 | Use the random victim index instead of `wr_idx` |
| wr_idx | input | IDX_W | Target entry for an indexed write |
| wr_vpn2 | input | VA_W-13 | Virtual pair number to store |
| wr_asid | input | ASID_W | Identifier to store |
| wr_glob | input | 1 | Global flag to store |
| wr_psz | input | 3 | Page size code to store |
| wr_pfn0 | input | PA_W-12 | Frame number of the even page |
| wr_pfn1 | input | PA_W-12 | Frame number of the odd page |
| wr_v0 | input | 1 | Valid bit of the even page |
| wr_v1 | input | 1 | Valid bit of the odd page |
| wired_we | input | 1 | Load the locked count |
| wired_val | input | CNT_W | New locked count |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Translation found |
| res_miss | output | 1 | Translation not found |
| res_pa | output | PA_W | Physical address on a hit, 0 otherwise |

## Verification
Some rules are checked by assertions on every cycle. The first group concerns result timing: a result appears exactly one cycle after a request, hit and miss never assert together, and the outputs stay at zero when no result is present. The second group concerns the random victim: it always stays between the locked count and the top entry, steps down by one, and reloads after the locked count is written. The third is that an indexed write lands in its entry. The remaining behaviours need directed bench scenarios: address matching under each page size, even/odd selection, the identifier and global rules, priority between duplicate entries, out-of-range writes, write-versus-lookup ordering in one cycle, and the exact victim chosen after a given delay and a burst of random writes.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
   localparam int PSZ_W      = 3;
   localparam int BASE_SHIFT = 12;
   localparam int SEL_W      = 13;   // va bits 24:12 hold every possible half selector
   localparam int OFF_W      = 25;   // largest in-page offset plus one pair bit

   typedef enum logic [PSZ_W-1:0] {
      PSZ_4K   = 3'd0,
      PSZ_16K  = 3'd1,
      PSZ_64K  = 3'd2,
      PSZ_256K = 3'd3,
      PSZ_1M   = 3'd4,
      PSZ_4M   = 3'd5,
      PSZ_16M  = 3'd6,
      PSZ_16MX = 3'd7
   } psz_e;

   // map the stored code onto the exponent actually used (7 folds onto 6)
   function automatic logic [PSZ_W-1:0] psz_exp(input logic [PSZ_W-1:0] code);
      psz_e c;
      c = psz_e'(code);
      return (c == PSZ_16MX) ? PSZ_16M : code;
   endfunction
endpackage

// File: rtl/ptlb_slot.sv
module ptlb_slot
   import ptlb_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 36,
   parameter int ASID_W = 8,
   localparam int VPN2_W = VA_W - 13,
   localparam int PFN_W  = PA_W - BASE_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [VPN2_W-1:0]  w_vpn2,
   input  logic [ASID_W-1:0]  w_asid,
   input  logic               w_glob,
   input  logic [PSZ_W-1:0]   w_psz,
   input  logic [PFN_W-1:0]   w_pfn0,
   input  logic [PFN_W-1:0]   w_pfn1,
   input  logic               w_v0,
   input  logic               w_v1,
   input  logic [VPN2_W-1:0]  lk_vpn2,
   input  logic [SEL_W-1:0]   lk_sel,
   input  logic [ASID_W-1:0]  lk_asid,
   output logic               tag_hit,
   output logic               half_v,
   output logic [PFN_W-1:0]   half_pfn,
   output logic [PSZ_W-1:0]   size_k
);
   logic [VPN2_W-1:0] vpn2_q;
   logic [ASID_W-1:0] asid_q;
   logic              glob_q;
   logic [PSZ_W-1:0]  psz_q;
   logic [PFN_W-1:0]  pfn0_q, pfn1_q;
   logic              v0_q, v1_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn2_q <= '0;
         asid_q <= '0;
         glob_q <= 1'b0;
         psz_q  <= '0;
         pfn0_q <= '0;
         pfn1_q <= '0;
         v0_q   <= 1'b0;
         v1_q   <= 1'b0;
      end else if (we) begin
         vpn2_q <= w_vpn2;
         asid_q <= w_asid;
         glob_q <= w_glob;
         psz_q  <= w_psz;
         pfn0_q <= w_pfn0;
         pfn1_q <= w_pfn1;
         v0_q   <= w_v0;
         v1_q   <= w_v1;
      end
   end

   logic [PSZ_W-1:0]  k;
   logic [3:0]        twice_k;
   logic [VPN2_W-1:0] keep_mask;
   logic              odd;
   logic              asid_ok;

   always_comb begin
      k         = psz_exp(psz_q);
      twice_k   = {k, 1'b0};
      keep_mask = {VPN2_W{1'b1}} << twice_k;
      odd       = lk_sel[twice_k];
      asid_ok   = glob_q || (asid_q == lk_asid);
      tag_hit   = asid_ok && (((vpn2_q ^ lk_vpn2) & keep_mask) == '0);
      half_v    = odd ? v1_q : v0_q;
      half_pfn  = odd ? pfn1_q : pfn0_q;
      size_k    = k;
   end

   // R6: a write issued to this slot is visible in its storage one cycle later
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (vpn2_q == $past(w_vpn2)) && (pfn0_q == $past(w_pfn0)) &&
             (pfn1_q == $past(w_pfn1)) && (v0_q == $past(w_v0)) && (v1_q == $past(w_v1)));
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
   parameter int NUM_ENTRIES = 48,
   localparam int IDX_W = $clog2(NUM_ENTRIES),
   localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wired_we,
   input  logic [CNT_W-1:0]  wired_val,
   output logic [IDX_W-1:0]  victim
);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(NUM_ENTRIES - 1);

   logic [CNT_W-1:0] wired_q;
   logic [CNT_W-1:0] rnd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wired_q <= '0;
         rnd_q   <= TOP;
      end else if (wired_we) begin
         wired_q <= wired_val;
         rnd_q   <= TOP;
      end else if (rnd_q <= wired_q) begin
         rnd_q   <= TOP;
      end else begin
         rnd_q   <= rnd_q - 1'b1;
      end
   end

   assign victim = rnd_q[IDX_W-1:0];

   // R7: the victim never falls below the locked count nor above the top entry
   a_r7_victim_window: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_q <= TOP) && ((rnd_q >= wired_q) || (rnd_q == TOP)));

   // R7: loading the locked count restarts the victim at the top entry
   a_r7_wired_reload: assert property (@(posedge clk) disable iff (!rst_n)
      wired_we |=> (rnd_q == TOP));

   // R7: above the locked count the victim steps down by exactly one
   a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!wired_we && (rnd_q > wired_q)) |=> (rnd_q == $past(rnd_q) - 1'b1));
endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve
   import ptlb_pkg::*;
#(
   parameter int NUM_ENTRIES = 48,
   parameter int PA_W        = 36,
   localparam int PFN_W = PA_W - BASE_SHIFT
) (
   input  logic [NUM_ENTRIES-1:0] tag_hit,
   input  logic [NUM_ENTRIES-1:0] half_v,
   input  logic [PFN_W-1:0]       half_pfn [NUM_ENTRIES],
   input  logic [PSZ_W-1:0]       size_k   [NUM_ENTRIES],
   input  logic [OFF_W-1:0]       lk_off,
   output logic                   found,
   output logic [PA_W-1:0]        pa
);
   logic              any_tag;
   logic              pick_v;
   logic [PFN_W-1:0]  pick_pfn;
   logic [PSZ_W-1:0]  pick_k;
   logic [4:0]        shift;
   logic [PA_W-1:0]   off_mask;
   logic [PA_W-1:0]   off_ext;

   // scan from the top so the lowest matching entry is the last to win
   always_comb begin
      any_tag  = 1'b0;
      pick_v   = 1'b0;
      pick_pfn = '0;
      pick_k   = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (tag_hit[i]) begin
            any_tag  = 1'b1;
            pick_v   = half_v[i];
            pick_pfn = half_pfn[i];
            pick_k   = size_k[i];
         end
      end
   end

   always_comb begin
      shift    = 5'(BASE_SHIFT) + {1'b0, pick_k, 1'b0};
      off_mask = ~({PA_W{1'b1}} << shift);
      off_ext  = {{(PA_W - OFF_W){1'b0}}, lk_off};
      found    = any_tag && pick_v;
      pa       = found ? (({pick_pfn, {BASE_SHIFT{1'b0}}} & ~off_mask) | (off_ext & off_mask))
                       : '0;
   end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
   import ptlb_pkg::*;
#(
   parameter int NUM_ENTRIES = 48,
   parameter int VA_W        = 32,
   parameter int PA_W        = 36,
   parameter int ASID_W      = 8,
   localparam int IDX_W  = $clog2(NUM_ENTRIES),
   localparam int CNT_W  = $clog2(NUM_ENTRIES + 1),
   localparam int VPN2_W = VA_W - 13,
   localparam int PFN_W  = PA_W - BASE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              wr_en,
   input  logic              wr_rand,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic [PSZ_W-1:0]  wr_psz,
   input  logic [PFN_W-1:0]  wr_pfn0,
   input  logic [PFN_W-1:0]  wr_pfn1,
   input  logic              wr_v0,
   input  logic              wr_v1,
   input  logic              wired_we,
   input  logic [CNT_W-1:0]  wired_val,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_miss,
   output logic [PA_W-1:0]   res_pa
);
   // elaboration-time parameter checks
   if (NUM_ENTRIES < 2 || NUM_ENTRIES > 64) begin : g_bad_entries
      $error("ptlb_top: NUM_ENTRIES must lie in 2..64");
   end
   if (VA_W < 26 || VA_W > 64) begin : g_bad_va
      $error("ptlb_top: VA_W must lie in 26..64");
   end
   if (PA_W < 26 || PA_W > 64) begin : g_bad_pa
      $error("ptlb_top: PA_W must lie in 26..64");
   end
   if (ASID_W < 1) begin : g_bad_asid
      $error("ptlb_top: ASID_W must be positive");
   end

   logic [IDX_W-1:0]       victim;
   logic [IDX_W-1:0]       target;
   logic                   target_ok;
   logic [NUM_ENTRIES-1:0] slot_we;
   logic [NUM_ENTRIES-1:0] slot_tag;
   logic [NUM_ENTRIES-1:0] slot_v;
   logic [PFN_W-1:0]       slot_pfn [NUM_ENTRIES];
   logic [PSZ_W-1:0]       slot_k   [NUM_ENTRIES];
   logic                   found;
   logic [PA_W-1:0]        pa_c;

   ptlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .wired_we  (wired_we),
      .wired_val (wired_val),
      .victim    (victim)
   );

   assign target    = wr_rand ? victim : wr_idx;
   assign target_ok = ({1'b0, target} < (IDX_W + 1)'(NUM_ENTRIES));

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
      assign slot_we[i] = wr_en && target_ok && (target == IDX_W'(i));

      ptlb_slot #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (slot_we[i]),
         .w_vpn2   (wr_vpn2),
         .w_asid   (wr_asid),
         .w_glob   (wr_glob),
         .w_psz    (wr_psz),
         .w_pfn0   (wr_pfn0),
         .w_pfn1   (wr_pfn1),
         .w_v0     (wr_v0),
         .w_v1     (wr_v1),
         .lk_vpn2  (lk_va[VA_W-1:13]),
         .lk_sel   (lk_va[BASE_SHIFT+SEL_W-1:BASE_SHIFT]),
         .lk_asid  (lk_asid),
         .tag_hit  (slot_tag[i]),
         .half_v   (slot_v[i]),
         .half_pfn (slot_pfn[i]),
         .size_k   (slot_k[i])
      );
   end

   ptlb_resolve #(.NUM_ENTRIES(NUM_ENTRIES), .PA_W(PA_W)) u_resolve (
      .tag_hit  (slot_tag),
      .half_v   (slot_v),
      .half_pfn (slot_pfn),
      .size_k   (slot_k),
      .lk_off   (lk_va[OFF_W-1:0]),
      .found    (found),
      .pa       (pa_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_miss  <= 1'b0;
         res_pa    <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= lk_valid && found;
         res_miss  <= lk_valid && !found;
         res_pa    <= lk_valid ? pa_c : '0;
      end
   end

   // R2: every request yields a result on the very next cycle
   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);

   // R2: no result appears without a request
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);

   // R2: a result is either a hit or a miss, never both
   a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hit != res_miss));

   // R1: idle outputs rest at zero
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_hit && !res_miss && (res_pa == '0)));

   // R5: a miss never carries an address
   a_r5_miss_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss |-> (res_pa == '0));
endmodule

// File: tb/ptlb_top_bench.sv
module ptlb_top_bench;
   localparam int N    = 48;
   localparam int TOPI = N - 1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid;
   logic [31:0] lk_va;
   logic [7:0]  lk_asid;
   logic        wr_en, wr_rand;
   logic [5:0]  wr_idx;
   logic [18:0] wr_vpn2;
   logic [7:0]  wr_asid;
   logic        wr_glob;
   logic [2:0]  wr_psz;
   logic [23:0] wr_pfn0, wr_pfn1;
   logic        wr_v0, wr_v1;
   logic        wired_we;
   logic [5:0]  wired_val;
   logic        res_valid, res_hit, res_miss;
   logic [35:0] res_pa;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   bit          q_hit [$];
   logic [35:0] q_pa  [$];
   string       q_tag [$];

   always #4 clk = ~clk;

   ptlb_top u_ptlb_top (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
      .wr_en(wr_en), .wr_rand(wr_rand), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
      .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_psz(wr_psz), .wr_pfn0(wr_pfn0),
      .wr_pfn1(wr_pfn1), .wr_v0(wr_v0), .wr_v1(wr_v1), .wired_we(wired_we),
      .wired_val(wired_val), .res_valid(res_valid), .res_hit(res_hit),
      .res_miss(res_miss), .res_pa(res_pa)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected address from R4, computed from the stored frame, size code and va
   function automatic logic [35:0] exp_pa(input logic [23:0] pfn, input logic [2:0] code,
                                          input logic [31:0] va);
      int k;
      logic [35:0] m;
      k = (code > 3'd6) ? 6 : int'(code);
      m = (36'd1 << (12 + 2 * k)) - 36'd1;
      return ({pfn, 12'h000} & ~m) | ({4'h0, va} & m);
   endfunction

   task automatic put_write(input int idx, input bit rnd, input logic [18:0] vpn2,
                            input logic [7:0] asid, input bit g, input logic [2:0] psz,
                            input logic [23:0] p0, input logic [23:0] p1, input bit v0, input bit v1);
      wr_en = 1'b1; wr_rand = rnd; wr_idx = 6'(idx); wr_vpn2 = vpn2; wr_asid = asid;
      wr_glob = g; wr_psz = psz; wr_pfn0 = p0; wr_pfn1 = p1; wr_v0 = v0; wr_v1 = v1;
   endtask

   task automatic put_look(input logic [31:0] va, input logic [7:0] asid, input bit hit,
                           input logic [35:0] pa, input string tag);
      lk_valid = 1'b1; lk_va = va; lk_asid = asid;
      q_hit.push_back(hit);
      q_pa.push_back(hit ? pa : 36'h0);
      q_tag.push_back(tag);
   endtask

   task automatic step();
      @(negedge clk);
      wr_en = 1'b0; wr_rand = 1'b0; lk_valid = 1'b0; wired_we = 1'b0;
   endtask

   task automatic do_write(input int idx, input bit rnd, input logic [18:0] vpn2,
                           input logic [7:0] asid, input bit g, input logic [2:0] psz,
                           input logic [23:0] p0, input logic [23:0] p1, input bit v0, input bit v1);
      put_write(idx, rnd, vpn2, asid, g, psz, p0, p1, v0, v1);
      step();
   endtask

   task automatic do_look(input logic [31:0] va, input logic [7:0] asid, input bit hit,
                          input logic [35:0] pa, input string tag);
      put_look(va, asid, hit, pa, tag);
      step();
   endtask

   task automatic do_wired(input int w);
      wired_we = 1'b1; wired_val = 6'(w);
      step();
   endtask

   // scoreboard monitor: one expected item per result
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (q_hit.size() == 0) begin
            check(1'b0, "R2 unexpected result", 64'(res_valid), 64'h0);
         end else begin
            bit          eh;
            logic [35:0] ep;
            string       et;
            eh = q_hit.pop_front();
            ep = q_pa.pop_front();
            et = q_tag.pop_front();
            check(res_hit == eh && res_miss == !eh && res_pa == ep, et,
                  {27'h0, res_hit, res_pa}, {27'h0, eh, ep});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 64'h0, 64'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_asid = '0;
      wr_en = 1'b0; wr_rand = 1'b0; wr_idx = '0; wr_vpn2 = '0; wr_asid = '0; wr_glob = 1'b0;
      wr_psz = '0; wr_pfn0 = '0; wr_pfn1 = '0; wr_v0 = 1'b0; wr_v1 = 1'b0;
      wired_we = 1'b0; wired_val = '0;
      repeat (3) @(negedge clk);
      check(res_valid == 0 && res_hit == 0 && res_miss == 0 && res_pa == 0,
            "R1 reset outputs", {res_valid, res_hit, res_miss, res_pa}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty buffer misses
      do_look(32'h1234_5000, 8'd0, 1'b0, 36'h0, "R1 empty miss");

      // R3/R4: 4K pair, both halves
      do_write(0, 0, 19'h12345, 8'd5, 0, 3'd0, 24'h0A0001, 24'h0B0002, 1, 1);
      do_look({19'h12345, 1'b0, 12'hABC}, 8'd5, 1'b1,
              exp_pa(24'h0A0001, 3'd0, {19'h12345, 1'b0, 12'hABC}), "R4 4K even");
      do_look({19'h12345, 1'b1, 12'h123}, 8'd5, 1'b1,
              exp_pa(24'h0B0002, 3'd0, {19'h12345, 1'b1, 12'h123}), "R4 4K odd");
      do_look({19'h12344, 1'b0, 12'h000}, 8'd5, 1'b0, 36'h0, "R3 tag bit differs");

      // R10: identifier rules
      do_look({19'h12345, 1'b0, 12'h000}, 8'd6, 1'b0, 36'h0, "R10 asid mismatch");
      do_write(1, 0, 19'h33333, 8'd2, 1, 3'd0, 24'h111111, 24'h222222, 1, 1);
      do_look({19'h33333, 1'b1, 12'h0FF}, 8'd9, 1'b1,
              exp_pa(24'h222222, 3'd0, {19'h33333, 1'b1, 12'h0FF}), "R10 global any asid");

      // R4: 256K pages, low pair-number bits ignored
      do_write(2, 0, 19'h2A5C0, 8'd5, 0, 3'd3, 24'h123456, 24'hABCDEF, 1, 1);
      do_look({19'h2A5EF, 13'h1A2B}, 8'd5, 1'b1,
              exp_pa(24'hABCDEF, 3'd3, {19'h2A5EF, 13'h1A2B}), "R4 256K odd");
      do_look({19'h2A5C7, 13'h0F0F}, 8'd5, 1'b1,
              exp_pa(24'h123456, 3'd3, {19'h2A5C7, 13'h0F0F}), "R4 256K even");

      // R4: 16M pages and code 7 treated as 16M
      do_write(3, 0, 19'h40000, 8'd5, 0, 3'd6, 24'hC00000, 24'hD00000, 1, 1);
      do_look({19'h40FFF, 13'h0555}, 8'd5, 1'b1,
              exp_pa(24'hD00000, 3'd6, {19'h40FFF, 13'h0555}), "R4 16M odd");
      do_look({19'h407FF, 13'h1FFF}, 8'd5, 1'b1,
              exp_pa(24'hC00000, 3'd6, {19'h407FF, 13'h1FFF}), "R4 16M even");
      do_write(4, 0, 19'h51000, 8'd5, 0, 3'd7, 24'hE00000, 24'hF00000, 1, 1);
      do_look({19'h51800, 13'h0001}, 8'd5, 1'b1,
              exp_pa(24'hF00000, 3'd6, {19'h51800, 13'h0001}), "R4 code7 as 16M");
      do_look({19'h52000, 13'h0001}, 8'd5, 1'b0, 36'h0, "R4 code7 upper bit compared");

      // R5: invalid half
      do_write(5, 0, 19'h05555, 8'd5, 0, 3'd0, 24'h000555, 24'h000AAA, 1, 0);
      do_look({19'h05555, 1'b1, 12'h010}, 8'd5, 1'b0, 36'h0, "R5 invalid odd miss");
      do_look({19'h05555, 1'b0, 12'h010}, 8'd5, 1'b1,
              exp_pa(24'h000555, 3'd0, {19'h05555, 1'b0, 12'h010}), "R5 valid even hit");

      // R8: duplicates, lowest index decides
      do_write(6, 0, 19'h06666, 8'd5, 0, 3'd0, 24'h006006, 24'h006006, 1, 1);
      do_write(7, 0, 19'h06666, 8'd5, 0, 3'd0, 24'h007007, 24'h007007, 1, 1);
      do_look({19'h06666, 1'b0, 12'h004}, 8'd5, 1'b1,
              exp_pa(24'h006006, 3'd0, {19'h06666, 1'b0, 12'h004}), "R8 lowest entry wins");
      do_write(8, 0, 19'h08888, 8'd5, 0, 3'd0, 24'h008008, 24'h008008, 0, 0);
      do_write(9, 0, 19'h08888, 8'd5, 0, 3'd0, 24'h009009, 24'h009009, 1, 1);
      do_look({19'h08888, 1'b0, 12'h004}, 8'd5, 1'b0, 36'h0, "R8 lowest invalid decides");

      // R6: write and lookup in one cycle
      put_write(0, 0, 19'h12345, 8'd5, 0, 3'd0, 24'h0C0C0C, 24'h0D0D0D, 1, 1);
      put_look({19'h12345, 1'b0, 12'h777}, 8'd5, 1'b1,
               exp_pa(24'h0A0001, 3'd0, {19'h12345, 1'b0, 12'h777}), "R6 same cycle old");
      step();
      do_look({19'h12345, 1'b0, 12'h777}, 8'd5, 1'b1,
              exp_pa(24'h0C0C0C, 3'd0, {19'h12345, 1'b0, 12'h777}), "R6 next cycle new");

      // R9: out-of-range index
      do_write(50, 0, 19'h09999, 8'd5, 0, 3'd0, 24'h009999, 24'h009999, 1, 1);
      do_look({19'h09999, 1'b0, 12'h000}, 8'd5, 1'b0, 36'h0, "R9 out-of-range ignored");

      // R7: fill every entry with a distinct tag
      for (int i = 0; i < N; i++)
         do_write(i, 0, 19'h10000 + 19'(i), 8'd1, 0, 3'd0, 24'h100 + 24'(i), 24'h0, 1, 1);

      do_wired(44);
      do_write(0, 1, 19'h7ABCD, 8'd1, 0, 3'd0, 24'h7ABCD, 24'h0, 1, 1);   // victim 47
      do_look({19'h10000 + 19'(TOPI), 13'h0}, 8'd1, 1'b0, 36'h0, "R7 first victim is top");
      do_look({19'h7ABCD, 13'h0}, 8'd1, 1'b1, {24'h7ABCD, 12'h000}, "R7 random write hit");
      do_look({19'h10000 + 19'd46, 13'h0}, 8'd1, 1'b1, {24'h100 + 24'd46, 12'h000}, "R7 46 kept");

      do_wired(44);
      repeat (5) step();
      do_write(0, 1, 19'h7BBBB, 8'd1, 0, 3'd0, 24'h7BBBB, 24'h0, 1, 1);   // 47-(5 mod 4)=46
      do_look({19'h10000 + 19'd46, 13'h0}, 8'd1, 1'b0, 36'h0, "R7 delayed victim wraps");
      do_look({19'h7BBBB, 13'h0}, 8'd1, 1'b1, {24'h7BBBB, 12'h000}, "R7 delayed write hit");
      do_look({19'h7ABCD, 13'h0}, 8'd1, 1'b1, {24'h7ABCD, 12'h000}, "R7 earlier write kept");

      do_wired(44);
      for (int j = 0; j < 10; j++)
         do_write(0, 1, 19'h60000 + 19'(j), 8'd1, 0, 3'd0, 24'h600 + 24'(j), 24'h0, 1, 1);
      for (int j = 0; j < 10; j++)
         do_look({19'h60000 + 19'(j), 13'h0}, 8'd1, (j >= 6), {24'h600 + 24'(j), 12'h000},
                 $sformatf("R7 burst write %0d", j));
      for (int i = 0; i < 44; i++)
         do_look({19'h10000 + 19'(i), 13'h0}, 8'd1, 1'b1, {24'h100 + 24'(i), 12'h000},
                 $sformatf("R7 locked entry %0d intact", i));

      repeat (3) step();
      check(q_hit.size() == 0, "R2 all results returned", 64'(q_hit.size()), 64'h0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule